// File: doc/BRIEF.md
# Packed Colour Lookup Table with RGB Expansion

This block is a 256-entry colour lookup table for a display pipeline. Storage is arranged as 128 words of 32 bits, each word holding two 16-bit colour entries. A register bus writes and reads whole words, so software loads two colours per access. The pixel path presents an 8-bit colour index and receives a 24-bit RGB colour one clock later, with a valid flag that follows the request.

Each stored entry carries three 5-bit colour fields and a spare intensity bit that the lookup ignores. On the pixel side each 5-bit field is widened to 8 bits by appending three zero bits. A swap control selects which stored field becomes red and which becomes blue, so the same table serves panels wired RGB or BGR.

Top module: `clut_palette`

## Requirements
- R1: The table holds 256 entries in 128 words; entry 2n is bits [15:0] of word n and entry 2n+1 is bits [31:16], so index bit 0 picks the half and index bits [7:1] pick the word.
- R2: Within an entry, bits [4:0] are the low field, bits [9:5] are green, bits [14:10] are the high field; bit 15 has no effect on the pixel output.
- R3: Each 5-bit field is widened to 8 bits as {field, 3'b000}; output bits [23:16] are red, [15:8] green, [7:0] blue.
- R4: With `swap_rb` low at request time, red comes from the low field and blue from the high field; with `swap_rb` high the two are exchanged. Green is unaffected.
- R5: A bus read returns, one cycle after the address is presented, the exact 32-bit word last written there, including both intensity bits.
- R6: `pix_valid_out` equals `pix_valid_in` of the previous cycle, and `pix_rgb` in that cycle reflects the index and swap setting sampled in the previous cycle.
- R7: When a bus write and a pixel lookup hit the same word in the same cycle, the pixel output (and the bus read data) carry the word's old contents; the new value is seen from the next lookup on.
- R8: After reset every word reads as zero, `pix_valid_out` is low and `pix_rgb` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Word address (byte offset minus table base, divided by 4) |
| bus_wr_en | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data, two packed entries |
| bus_rdata | output | 32 | Registered read data of the addressed word |
| pix_index | input | 8 | Colour index to look up |
| pix_valid_in | input | 1 | Lookup request qualifier |
| swap_rb | input | 1 | Exchange red and blue fields |
| pix_rgb | output | 24 | Expanded colour, red in the top byte |
| pix_valid_out | output | 1 | Lookup result qualifier |

## Verification
The bench aims at entries whose spare bit is set, to expose a design that leaks bit 15 into blue or red, and at the all-ones entry where a replicated-bit expansion would yield FF instead of F8. It alternates the swap control per request so that a design sampling it a cycle late, or swapping green, gives wrong colours, and it reads odd and even indices of the same word to catch a reversed half select. A same-cycle write and lookup to one word catches a design that forwards the new data.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CH_W    = 5;
  localparam int OUT_W   = 8;
  localparam int ENTRY_W = 3 * CH_W + 1;
  localparam int WORD_W  = 2 * ENTRY_W;
  localparam int RGB_W   = 3 * OUT_W;

  // Widen one field by appending zero bits.
  function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] f);
    return {f, {(OUT_W-CH_W){1'b0}}};
  endfunction

  // Pick the half of a word addressed by the index low bit.
  function automatic logic [ENTRY_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                   input logic hi);
    return hi ? w[WORD_W-1:ENTRY_W] : w[ENTRY_W-1:0];
  endfunction

  // Turn a packed entry into a 24-bit colour, optionally swapping red and blue.
  function automatic logic [RGB_W-1:0] to_rgb(input logic [ENTRY_W-1:0] e,
                                              input logic swap);
    logic [CH_W-1:0] lo_f, mid_f, hi_f;
    lo_f  = e[CH_W-1:0];
    mid_f = e[2*CH_W-1:CH_W];
    hi_f  = e[3*CH_W-1:2*CH_W];
    if (swap) return {widen(hi_f), widen(mid_f), widen(lo_f)};
    return {widen(lo_f), widen(mid_f), widen(hi_f)};
  endfunction
endpackage

// File: rtl/clut_store.sv
module clut_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] bus_q,
  input  logic [AW-1:0]     pix_addr,
  input  logic              pix_req,
  output logic [WORD_W-1:0] pix_q
);
  logic [WORD_W-1:0] mem [WORDS];
  logic              collide;

  assign collide = wr_en && pix_req && (wr_addr == pix_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      bus_q <= '0;
      pix_q <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      bus_q <= mem[wr_addr];
      pix_q <= mem[pix_addr];
    end
  end

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en ##1 (!wr_en && $stable(wr_addr))) |=> bus_q == $past(wr_data, 2)); // R5

  AST_COLLIDE_OLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> pix_q == bus_q); // R7
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_sel,
  input  logic              swap,
  input  logic              req,
  input  logic [WORD_W-1:0] word_q,
  output logic [RGB_W-1:0]  rgb,
  output logic              valid
);
  logic hi_q, swap_q, req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      swap_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      hi_q   <= hi_sel;
      swap_q <= swap;
      req_q  <= req;
    end
  end

  assign rgb   = to_rgb(pick_half(word_q, hi_q), swap_q);
  assign valid = req_q;

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    valid == $past(req)); // R6

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rgb[2:0] == 3'b0 && rgb[10:8] == 3'b0 && rgb[18:16] == 3'b0)); // R3
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int WORDS  = ENTRIES / 2,
  localparam int AW     = $clog2(WORDS),
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr_en,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [IW-1:0]     pix_index,
  input  logic              pix_valid_in,
  input  logic              swap_rb,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              pix_valid_out
);
  logic [WORD_W-1:0] pix_word;

  clut_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(bus_addr), .wr_en(bus_wr_en), .wr_data(bus_wdata),
    .bus_q(bus_rdata),
    .pix_addr(pix_index[IW-1:1]), .pix_req(pix_valid_in),
    .pix_q(pix_word)
  );

  clut_expand u_expand (
    .clk(clk), .rst_n(rst_n),
    .hi_sel(pix_index[0]), .swap(swap_rb), .req(pix_valid_in),
    .word_q(pix_word), .rgb(pix_rgb), .valid(pix_valid_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!pix_valid_out && pix_rgb == '0)); // R8
endmodule

// File: tb/tb_clut_palette.sv
module tb_clut_palette;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  bus_addr = 0;
  logic        bus_wr_en = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_index = 0;
  logic        pix_valid_in = 0;
  logic        swap_rb = 0;
  logic [23:0] pix_rgb;
  logic        pix_valid_out;

  int checks = 0, fails = 0;
  logic [31:0] model [128];

  always #5 clk = ~clk;

  clut_palette dut (.*);

  function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic odd,
                                          input logic sw);
    logic [15:0] e;
    logic [7:0] a, g, c;
    e = odd ? w[31:16] : w[15:0];
    a = {e[4:0], 3'd0};
    g = {e[9:5], 3'd0};
    c = {e[14:10], 3'd0};
    return sw ? {c, g, a} : {a, g, c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1;
    model[a] = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [6:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 0;
    @(negedge clk);
    check(req, bus_rdata, model[a]);
  endtask

  task automatic look(input string req, input logic [7:0] idx, input logic sw);
    @(negedge clk);
    pix_index = idx; swap_rb = sw; pix_valid_in = 1;
    @(negedge clk);
    pix_valid_in = 0;
    check({req, " valid"}, {31'd0, pix_valid_out}, 32'd1);
    check(req, {8'd0, pix_rgb}, {8'd0, exp_rgb(model[idx[7:1]], idx[0], sw)});
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 rgb", {8'd0, pix_rgb}, 0);
    check("R8 valid", {31'd0, pix_valid_out}, 0);
    rst_n = 1;
    rd("R8 mem", 7'd5);
    look("R8 lookup zero", 8'd77, 0);

    // R1 R2 R3: all-ones and spare bits
    wr(7'd0, 32'hFFFF_7FFF);
    look("R3 all ones", 8'd0, 0);
    check("R3 F8", {8'd0, pix_rgb}, 32'h00F8F8F8);
    look("R1 odd half", 8'd1, 0);
    wr(7'd1, 32'h8000_8000);
    look("R2 spare bit ignored", 8'd2, 0);
    check("R2 zero", {8'd0, pix_rgb}, 0);
    rd("R5 raw spare bits", 7'd1);
    // R4 distinct fields
    wr(7'd127, {1'b0, 5'h03, 5'h11, 5'h1C, 1'b1, 5'h01, 5'h0A, 5'h15});
    look("R4 no swap", 8'd254, 0);
    check("R4 red low field", {24'd0, pix_rgb[23:16]}, {24'd0, 5'h15, 3'd0});
    look("R4 swap", 8'd254, 1);
    check("R4 red high field", {24'd0, pix_rgb[23:16]}, {24'd0, 5'h01, 3'd0});
    look("R4 swap odd", 8'd255, 1);

    // R7 collision: same word written and looked up in one cycle
    wr(7'd9, 32'h1234_5678);
    @(negedge clk);
    bus_addr = 7'd9; bus_wdata = 32'hABCD_EF01; bus_wr_en = 1;
    pix_index = 8'd18; swap_rb = 0; pix_valid_in = 1;
    @(negedge clk);
    bus_wr_en = 0; pix_valid_in = 0;
    check("R7 old pixel", {8'd0, pix_rgb}, {8'd0, exp_rgb(32'h1234_5678, 0, 0)});
    check("R7 old bus", bus_rdata, 32'h1234_5678);
    model[9] = 32'hABCD_EF01;
    look("R7 new after", 8'd18, 0);

    // R6 back-to-back lookups then idle
    @(negedge clk);
    pix_index = 8'd0; pix_valid_in = 1; swap_rb = 0;
    @(negedge clk);
    pix_index = 8'd255; swap_rb = 1;
    check("R6 first", {8'd0, pix_rgb}, {8'd0, exp_rgb(model[0], 0, 0)});
    @(negedge clk);
    pix_valid_in = 0;
    check("R6 second", {8'd0, pix_rgb}, {8'd0, exp_rgb(model[127], 1, 1)});
    @(negedge clk);
    check("R6 valid drop", {31'd0, pix_valid_out}, 0);

    // random fill and mixed traffic
    for (int i = 0; i < 128; i++) wr(i[6:0], $urandom);
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 127), $urandom);
      else if ($urandom_range(0, 1) == 0) rd("R5 random", $urandom_range(0, 127));
      else look("R1 random", $urandom_range(0, 255), $urandom_range(0, 1));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule